// File: doc/BRIEF.md
# Star-to-Ring Topology Reconfiguration Controller

This block decides, every clock cycle, which links of a small on-chip network carry traffic. A central hub switch reaches each of `N` functional units (six by default) over a dedicated star link. Standby ring links join neighbouring units. Ring link `j` joins unit `j` and unit `(j+1) mod N`, and clockwise means increasing unit index. While the hub is healthy the controller keeps the star running. It wakes individual ring links to route around a dead star link, to share load with a congested star link, or to let two neighbouring units talk without going through the hub.

When the hub itself is reported lost, the controller drops every star link and lights the whole ring. It names the idlest unit as network master and issues a one-cycle request to roll the system back to the last healthy state held in the recorder unit. The recorder reaches the hub over a pair of redundant links. The controller steers recorder traffic onto the spare link when the primary one is faulty, and raises a fatal flag when both are faulty.

The controller is a three-state machine:
- **NET_STAR** is normal operation with a healthy hub.
- **NET_RESTORE** is the single cycle in which the hub loss is acted on.
- **NET_RING** is the standing ring mode, which is kept until reset.

The transitions are:
- **hub_lost** goes from NET_STAR to NET_RESTORE when `hub_fail` is sampled high.
- **restore_done** goes from NET_RESTORE to NET_RING unconditionally.
- **ring_hold** keeps NET_RING in NET_RING.
- **stay_star** keeps NET_STAR in NET_STAR.

Top module: `reconf_ctrl`

## Requirements
- R1: After reset, `star_en` is all ones, and `ring_en`, `bypass_en`, `split_sel`, `master_valid`, `master_id`, `restore_req` and `fatal_err` are zero. `rec_link_en` is 2'b01, which selects recorder link 0.
- R2: A `star_fault[u]` pulse makes `star_en[u]` go low one cycle later. It stays low until reset, whether or not the flag is still asserted.
- R3: For a faulted unit `u` with a healthy hub, let `d_cw` be the hop count to the nearest unit clockwise whose star link is not faulted, and `d_ccw` the hop count counter-clockwise. If `d_cw <= d_ccw`, ring links `u .. u+d_cw-1` (mod N) are enabled. Otherwise links `u-1 .. u-d_ccw` (mod N) are enabled. If no star link is healthy, the unit gets no ring links.
- R4: A `star_congest[u]` pulse on a unit with a healthy star link starts balancing for that unit. Balancing enables the same ring path as in R3 and keeps `star_en[u]` high. While balancing, `split_sel[u]` (0 = direct star link, 1 = ring path) toggles on each cycle in which `pkt_tick[u]` is high, starting from 0.
- R5: Balancing for a unit ends after `hold_cycles` consecutive sampled cycles with its congestion flag low (0 counts as 1). Its ring path and `split_sel` bit then return to 0.
- R6: With a healthy hub, `bypass_req[j]` enables ring link `j` and sets `bypass_en[j]` on the next cycle.
- R7: Once the hub is lost, `star_en` is 0, `ring_en` is all ones, and `bypass_en` and `split_sel` are 0.
- R8: `restore_req` is high for exactly one cycle, in the first cycle of the hub-lost configuration.
- R9: On hub loss, `master_id` is the unit with the largest `idle_level` sampled at that edge, with ties going to the lowest index. `master_valid` is set, and both are held until reset.
- R10: Recorder faults are sticky. `rec_link_en` is 2'b01 while link 0 is healthy, 2'b10 when only link 0 is faulty, and 2'b00 when both are faulty or the hub is lost. `fatal_err` is high exactly when both recorder links have been faulty.
- R11: Every output is a register that reflects the inputs sampled at the previous edge, and all outputs change together. Hub loss is sticky until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| star_fault | input | N | Per-unit star link fault flag (latched) |
| star_congest | input | N | Per-unit star link congestion flag |
| hub_fail | input | 1 | Hub switch lost (latched) |
| idle_level | input | N*IDLE_W | Per-unit idleness, unit u at bits u*IDLE_W upward; larger is idler |
| pkt_tick | input | N | A packet to unit u is being dispatched this cycle |
| bypass_req | input | N | Units j and j+1 want a direct neighbour link |
| rec_link_fault | input | 2 | Recorder link fault flags (latched) |
| hold_cycles | input | HOLD_W | Clear cycles needed to end balancing |
| star_en | output | N | Star link enables |
| ring_en | output | N | Ring link enables |
| bypass_en | output | N | Ring links enabled for hub bypass |
| split_sel | output | N | Path for the next packet: 0 star, 1 ring |
| master_valid | output | 1 | A unit has been made network master |
| master_id | output | IDX_W | Index of the master unit |
| restore_req | output | 1 | One-cycle request to restore the saved state |
| rec_link_en | output | 2 | Recorder link enables |
| fatal_err | output | 1 | Both recorder links lost |

## Verification
A corrupted fault latch shows up one cycle later as a wrong `star_en` bit and usually as a wrong ring path on `ring_en`, because every path choice depends on which neighbours are healthy. A wrong state-machine state is visible at once:
- Leaving NET_STAR early drops all star links.
- Skipping NET_RESTORE loses the `restore_req` pulse.
- Falling back from NET_RING re-enables star links, which are latched off.

A wrong balancing counter appears as `ring_en` and `split_sel` releasing a cycle early or late relative to `hold_cycles`. A wrong toggle shows as `split_sel` out of step with `pkt_tick`.

// File: rtl/reconf_pkg.sv
package reconf_pkg;

    typedef enum logic [1:0] {
        NET_STAR    = 2'd0,
        NET_RESTORE = 2'd1,
        NET_RING    = 2'd2
    } net_state_e;

endpackage

// File: rtl/ring_path_planner.sv
module ring_path_planner #(
    parameter int N     = 6,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0] ok,
    input  logic [N-1:0] need,
    output logic [N-1:0] links
);

    function automatic logic [N-1:0] path_for(input int u, input logic [N-1:0] healthy);
        int dcw;
        int dccw;
        logic [N-1:0] m;
        dcw  = 0;
        dccw = 0;
        m    = '0;
        for (int d = N - 1; d >= 1; d--) begin
            if (healthy[IDX_W'((u + d) % N)])     dcw  = d;
            if (healthy[IDX_W'((u - d + N) % N)]) dccw = d;
        end
        if (dcw != 0) begin
            if (dcw <= dccw) begin
                for (int k = 0; k < N - 1; k++)
                    if (k < dcw) m[IDX_W'((u + k) % N)] = 1'b1;
            end else begin
                for (int k = 0; k < N - 1; k++)
                    if (k < dccw) m[IDX_W'((u - 1 - k + 2 * N) % N)] = 1'b1;
            end
        end
        return m;
    endfunction

    logic [N-1:0] paths [N];

    for (genvar u = 0; u < N; u++) begin : g_unit
        assign paths[u] = need[u] ? path_for(u, ok) : '0;
    end

    always_comb begin
        links = '0;
        for (int u = 0; u < N; u++) links = links | paths[IDX_W'(u)];
    end

endmodule

// File: rtl/balance_tracker.sv
module balance_tracker #(
    parameter int N      = 6,
    parameter int HOLD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      elig,
    input  logic [N-1:0]      congest,
    input  logic [N-1:0]      pkt_tick,
    input  logic [HOLD_W-1:0] hold,
    output logic [N-1:0]      bal_nxt,
    output logic [N-1:0]      sel_q
);

    for (genvar u = 0; u < N; u++) begin : g_unit
        logic              bal_r;
        logic              sel_r;
        logic [HOLD_W-1:0] cnt_r;
        logic [HOLD_W:0]   cnt_inc;
        logic              keep;

        assign cnt_inc    = {1'b0, cnt_r} + {{HOLD_W{1'b0}}, 1'b1};
        assign keep       = bal_r & (cnt_inc < {1'b0, hold});
        assign bal_nxt[u] = elig[u] & (congest[u] | keep);
        assign sel_q[u]   = sel_r;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bal_r <= 1'b0;
                sel_r <= 1'b0;
                cnt_r <= '0;
            end else begin
                bal_r <= bal_nxt[u];
                sel_r <= bal_nxt[u] & (sel_r ^ pkt_tick[u]);
                cnt_r <= (congest[u] | ~bal_nxt[u]) ? '0 : cnt_r + 1'b1;
            end
        end
    end

endmodule

// File: rtl/master_picker.sv
module master_picker #(
    parameter int N      = 6,
    parameter int IDLE_W = 4,
    parameter int IDX_W  = 3
) (
    input  logic [N*IDLE_W-1:0] idle_level,
    output logic [IDX_W-1:0]    best
);

    logic [IDLE_W-1:0] lvl [N];

    for (genvar u = 0; u < N; u++) begin : g_unpack
        assign lvl[u] = idle_level[u*IDLE_W +: IDLE_W];
    end

    always_comb begin
        logic [IDLE_W-1:0] top;
        best = '0;
        top  = lvl[0];
        for (int u = 1; u < N; u++) begin
            if (lvl[IDX_W'(u)] > top) begin
                top  = lvl[IDX_W'(u)];
                best = IDX_W'(u);
            end
        end
    end

endmodule

// File: rtl/reconf_ctrl.sv
module reconf_ctrl
    import reconf_pkg::*;
#(
    parameter int N      = 6,
    parameter int IDLE_W = 4,
    parameter int HOLD_W = 8,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N-1:0]        star_fault,
    input  logic [N-1:0]        star_congest,
    input  logic                hub_fail,
    input  logic [N*IDLE_W-1:0] idle_level,
    input  logic [N-1:0]        pkt_tick,
    input  logic [N-1:0]        bypass_req,
    input  logic [1:0]          rec_link_fault,
    input  logic [HOLD_W-1:0]   hold_cycles,
    output logic [N-1:0]        star_en,
    output logic [N-1:0]        ring_en,
    output logic [N-1:0]        bypass_en,
    output logic [N-1:0]        split_sel,
    output logic                master_valid,
    output logic [IDX_W-1:0]    master_id,
    output logic                restore_req,
    output logic [1:0]          rec_link_en,
    output logic                fatal_err
);

    net_state_e state_q, state_d;

    logic [N-1:0]     flt_q, flt_d;
    logic [1:0]       rec_q, rec_d;
    logic             hub_ok_d;
    logic [N-1:0]     elig;
    logic [N-1:0]     bal_nxt;
    logic [N-1:0]     path_links;
    logic [IDX_W-1:0] best_unit;

    assign flt_d    = flt_q | star_fault;
    assign rec_d    = rec_q | rec_link_fault;
    assign hub_ok_d = (state_d == NET_STAR);
    assign elig     = hub_ok_d ? ~flt_d : '0;

    // next-state logic
    always_comb begin
        unique case (state_q)
            NET_STAR:    state_d = hub_fail ? NET_RESTORE : NET_STAR;
            NET_RESTORE: state_d = NET_RING;
            NET_RING:    state_d = NET_RING;
            default:     state_d = NET_STAR;
        endcase
    end

    // state and latched fault flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= NET_STAR;
            flt_q   <= '0;
            rec_q   <= '0;
        end else begin
            state_q <= state_d;
            flt_q   <= flt_d;
            rec_q   <= rec_d;
        end
    end

    balance_tracker #(.N(N), .HOLD_W(HOLD_W)) u_bal (
        .clk      (clk),
        .rst_n    (rst_n),
        .elig     (elig),
        .congest  (star_congest),
        .pkt_tick (pkt_tick),
        .hold     (hold_cycles),
        .bal_nxt  (bal_nxt),
        .sel_q    (split_sel)
    );

    ring_path_planner #(.N(N), .IDX_W(IDX_W)) u_plan (
        .ok    (~flt_d),
        .need  (flt_d | bal_nxt),
        .links (path_links)
    );

    master_picker #(.N(N), .IDLE_W(IDLE_W), .IDX_W(IDX_W)) u_pick (
        .idle_level (idle_level),
        .best       (best_unit)
    );

    // registered configuration outputs, all loaded at the same edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            star_en      <= '1;
            ring_en      <= '0;
            bypass_en    <= '0;
            master_valid <= 1'b0;
            master_id    <= '0;
            restore_req  <= 1'b0;
            rec_link_en  <= 2'b01;
            fatal_err    <= 1'b0;
        end else begin
            fatal_err <= &rec_d;
            unique case (state_d)
                NET_STAR: begin
                    star_en      <= ~flt_d;
                    ring_en      <= path_links | bypass_req;
                    bypass_en    <= bypass_req;
                    master_valid <= 1'b0;
                    restore_req  <= 1'b0;
                    rec_link_en  <= {rec_d[0] & ~rec_d[1], ~rec_d[0]};
                end
                NET_RESTORE: begin
                    star_en      <= '0;
                    ring_en      <= '1;
                    bypass_en    <= '0;
                    master_valid <= 1'b1;
                    master_id    <= best_unit;
                    restore_req  <= 1'b1;
                    rec_link_en  <= 2'b00;
                end
                NET_RING: begin
                    star_en      <= '0;
                    ring_en      <= '1;
                    bypass_en    <= '0;
                    master_valid <= 1'b1;
                    restore_req  <= 1'b0;
                    rec_link_en  <= 2'b00;
                end
                default: begin
                    star_en      <= '1;
                    ring_en      <= '0;
                    bypass_en    <= '0;
                    master_valid <= 1'b0;
                    restore_req  <= 1'b0;
                    rec_link_en  <= 2'b00;
                end
            endcase
        end
    end

endmodule

// File: rtl/reconf_ctrl_chk.sv
module reconf_ctrl_chk #(
    parameter int N     = 6,
    parameter int IDX_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N-1:0]     star_en,
    input logic [N-1:0]     ring_en,
    input logic [N-1:0]     bypass_en,
    input logic [N-1:0]     split_sel,
    input logic             master_valid,
    input logic [IDX_W-1:0] master_id,
    input logic             restore_req,
    input logic [1:0]       rec_link_en,
    input logic             fatal_err
);

    a_r2_star_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (star_en & ~$past(star_en)) == '0);

    a_r4_split_on_live_star: assert property (@(posedge clk) disable iff (!rst_n)
        (split_sel & ~star_en) == '0);

    a_r6_bypass_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
        (bypass_en & ~ring_en) == '0);

    a_r7_hub_lost_ring: assert property (@(posedge clk) disable iff (!rst_n)
        master_valid |-> (star_en == '0 && ring_en == '1 && split_sel == '0));

    a_r8_restore_single: assert property (@(posedge clk) disable iff (!rst_n)
        restore_req |=> !restore_req);

    a_r8_restore_on_takeover: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(master_valid) |-> restore_req);

    a_r9_master_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (master_valid && $past(master_valid)) |-> $stable(master_id));

    a_r10_rec_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rec_link_en));

    a_r10_fatal_cuts: assert property (@(posedge clk) disable iff (!rst_n)
        fatal_err |-> rec_link_en == 2'b00);

    a_r11_ring_mode_kept: assert property (@(posedge clk) disable iff (!rst_n)
        master_valid |=> master_valid);

endmodule

bind reconf_ctrl reconf_ctrl_chk #(.N(N), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/reconf_ctrl_test.sv
module reconf_ctrl_test;

    localparam int N      = 6;
    localparam int IDLE_W = 4;
    localparam int HOLD_W = 8;
    localparam int IDX_W  = 3;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [N-1:0]        star_fault = '0;
    logic [N-1:0]        star_congest = '0;
    logic                hub_fail = 1'b0;
    logic [N*IDLE_W-1:0] idle_level = '0;
    logic [N-1:0]        pkt_tick = '0;
    logic [N-1:0]        bypass_req = '0;
    logic [1:0]          rec_link_fault = '0;
    logic [HOLD_W-1:0]   hold_cycles = 8'd2;
    logic [N-1:0]        star_en, ring_en, bypass_en, split_sel;
    logic                master_valid, restore_req, fatal_err;
    logic [IDX_W-1:0]    master_id;
    logic [1:0]          rec_link_en;

    always #5 clk = ~clk;

    reconf_ctrl #(.N(N), .IDLE_W(IDLE_W), .HOLD_W(HOLD_W)) uut (.*);

    int n_chk  = 0;
    int n_fail = 0;

    // reference model state
    logic [N-1:0] m_flt, m_bal, m_sel;
    logic [1:0]   m_rec;
    int           m_stage;
    int           m_cnt [N];
    logic [N-1:0] e_star, e_ring, e_byp;
    logic         e_mv, e_rr, e_fatal;
    logic [IDX_W-1:0] e_mid;
    logic [1:0]   e_rec;

    task automatic check(string tag, string nm, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, nm, act, exp, $time);
        end
    endtask

    function automatic logic [N-1:0] bit_at(int i);
        return {{(N-1){1'b0}}, 1'b1} << i;
    endfunction

    function automatic logic [N-1:0] exp_path(int u, logic [N-1:0] ok);
        int cw = 0;
        int ccw = 0;
        logic [N-1:0] r = '0;
        for (int d = 1; d < N; d++) begin
            if (cw == 0 && (ok & bit_at((u + d) % N)) != 0) cw = d;
            if (ccw == 0 && (ok & bit_at((u + N - d) % N)) != 0) ccw = d;
        end
        if (cw == 0) return r;
        if (cw <= ccw) for (int k = 0; k < cw; k++) r = r | bit_at((u + k) % N);
        else for (int k = 0; k < ccw; k++) r = r | bit_at((u + N - 1 - k) % N);
        return r;
    endfunction

    function automatic logic [IDX_W-1:0] exp_master(logic [N*IDLE_W-1:0] lv);
        int best = 0;
        for (int u = 1; u < N; u++)
            if (lv[u*IDLE_W +: IDLE_W] > lv[best*IDLE_W +: IDLE_W]) best = u;
        return IDX_W'(best);
    endfunction

    task automatic model_reset();
        m_flt = '0; m_bal = '0; m_sel = '0; m_rec = '0; m_stage = 0;
        for (int u = 0; u < N; u++) m_cnt[u] = 0;
        e_star = '1; e_ring = '0; e_byp = '0; e_mv = 0; e_rr = 0; e_fatal = 0;
        e_mid = '0; e_rec = 2'b01;
    endtask

    task automatic model_step();
        logic [N-1:0] paths;
        int lim;
        lim     = (hold_cycles == 0) ? 1 : int'(hold_cycles);
        m_flt   = m_flt | star_fault;
        m_rec   = m_rec | rec_link_fault;
        e_fatal = &m_rec;
        if (m_stage == 0 && hub_fail) m_stage = 1;
        else if (m_stage != 0) m_stage = 2;
        if (m_stage == 0) begin
            for (int u = 0; u < N; u++) begin
                if ((m_flt & bit_at(u)) != 0) begin
                    m_bal = m_bal & ~bit_at(u); m_sel = m_sel & ~bit_at(u); m_cnt[u] = 0;
                end else if ((star_congest & bit_at(u)) != 0) begin
                    if ((pkt_tick & bit_at(u)) != 0) m_sel = m_sel ^ bit_at(u);
                    m_bal = m_bal | bit_at(u); m_cnt[u] = 0;
                end else if ((m_bal & bit_at(u)) != 0) begin
                    m_cnt[u]++;
                    if (m_cnt[u] >= lim) begin
                        m_bal = m_bal & ~bit_at(u); m_sel = m_sel & ~bit_at(u); m_cnt[u] = 0;
                    end else if ((pkt_tick & bit_at(u)) != 0) m_sel = m_sel ^ bit_at(u);
                end
            end
            paths = '0;
            for (int u = 0; u < N; u++)
                if (((m_flt | m_bal) & bit_at(u)) != 0) paths = paths | exp_path(u, ~m_flt);
            e_star = ~m_flt; e_ring = paths | bypass_req; e_byp = bypass_req;
            e_mv = 0; e_rr = 0;
            e_rec = !m_rec[0] ? 2'b01 : (!m_rec[1] ? 2'b10 : 2'b00);
        end else begin
            m_bal = '0; m_sel = '0;
            for (int u = 0; u < N; u++) m_cnt[u] = 0;
            if (m_stage == 1) e_mid = exp_master(idle_level);
            e_star = '0; e_ring = '1; e_byp = '0; e_mv = 1; e_rr = (m_stage == 1);
            e_rec = 2'b00;
        end
    endtask

    task automatic compare();
        check(m_stage != 0 ? "R7" : "R2", "star_en", 32'(star_en), 32'(e_star));
        check("R3", "ring_en", 32'(ring_en), 32'(e_ring));
        check("R6", "bypass_en", 32'(bypass_en), 32'(e_byp));
        check("R4", "split_sel", 32'(split_sel), 32'(m_sel));
        check("R11", "master_valid", 32'(master_valid), 32'(e_mv));
        if (e_mv) check("R9", "master_id", 32'(master_id), 32'(e_mid));
        check("R8", "restore_req", 32'(restore_req), 32'(e_rr));
        check("R10", "rec_link_en", 32'(rec_link_en), 32'(e_rec));
        check("R10", "fatal_err", 32'(fatal_err), 32'(e_fatal));
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic clear_inputs();
        star_fault = '0; star_congest = '0; hub_fail = 0; pkt_tick = '0;
        bypass_req = '0; rec_link_fault = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        clear_inputs();
        repeat (2) @(negedge clk);
        model_reset();
        // R1: reset values
        check("R1", "star_en", 32'(star_en), {32{1'b0}} | 32'(6'h3f));
        check("R1", "ring_en", 32'(ring_en), 32'd0);
        check("R1", "outputs", 32'({bypass_en, split_sel, master_valid, restore_req, fatal_err}), 32'd0);
        check("R1", "rec_link_en", 32'(rec_link_en), 32'd1);
        rst_n = 1;
    endtask

    task automatic rand_batch(int cycles, bit with_hub);
        hold_cycles = HOLD_W'(1 + $urandom % 4);
        for (int c = 0; c < cycles; c++) begin
            for (int u = 0; u < N; u++) begin
                star_fault[u]   = ($urandom % 150) == 0;
                star_congest[u] = ($urandom % 8) == 0;
                pkt_tick[u]     = $urandom % 2;
                bypass_req[u]   = ($urandom % 4) == 0;
            end
            rec_link_fault = {($urandom % 300) == 0, ($urandom % 300) == 0};
            idle_level     = N*IDLE_W'($urandom);
            hub_fail       = with_hub && (c == cycles / 2);
            step();
        end
        clear_inputs();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired R11 actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        do_reset();

        // R3: single fault, tie between directions goes clockwise
        star_fault = bit_at(2); step();
        star_fault = '0; step();
        check("R3", "cw tie path", 32'(ring_en), 32'(6'b000100));
        check("R2", "sticky fault", 32'(star_en), 32'(6'b111011));
        // R3: neighbour 3 also faulted -> unit 2 goes counter-clockwise
        star_fault = bit_at(3); step();
        star_fault = '0;
        check("R3", "ccw shorter", 32'(ring_en), 32'(6'b001010));

        // R4/R5: congestion balancing with hold of 3
        do_reset();
        hold_cycles = 8'd3;
        star_congest = bit_at(0); pkt_tick = bit_at(0); step();
        check("R4", "split first tick", 32'(split_sel), 32'(6'b000001));
        star_congest = '0; step();
        check("R4", "split second tick", 32'(split_sel), 32'(6'b000000));
        pkt_tick = '0; step();
        check("R5", "still balancing", 32'(ring_en), 32'(6'b000001));
        step();
        check("R5", "balance released", 32'(ring_en), 32'd0);
        check("R5", "split released", 32'(split_sel), 32'd0);

        // R6: bypass
        bypass_req = 6'b100010; step();
        check("R6", "bypass links", 32'(bypass_en), 32'(6'b100010));
        bypass_req = '0; step();

        // R10: recorder fallback then fatal
        rec_link_fault = 2'b01; step();
        check("R10", "spare link", 32'(rec_link_en), 32'd2);
        rec_link_fault = 2'b10; step();
        check("R10", "fatal", 32'(fatal_err), 32'd1);
        rec_link_fault = 2'b00;

        // R9: idleness tie -> lowest index; R8 pulse
        do_reset();
        idle_level = {4'd3, 4'd9, 4'd3, 4'd9, 4'd3, 4'd3};
        hub_fail = 1; step();
        hub_fail = 0;
        check("R9", "tie master", 32'(master_id), 32'd2);
        check("R8", "restore pulse", 32'(restore_req), 32'd1);
        idle_level = {4'd15, 20'd0}; step();
        check("R8", "restore ends", 32'(restore_req), 32'd0);
        check("R9", "master held", 32'(master_id), 32'd2);

        do_reset();
        idle_level = {N{4'd5}};
        hub_fail = 1; step();
        hub_fail = 0;
        check("R9", "all equal", 32'(master_id), 32'd0);

        // constrained random batches
        for (int b = 0; b < 8; b++) begin
            do_reset();
            rand_batch(700, b[0]);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule